// File: doc/BRIEF.md
# Banked Memory Window Translator

This block sits between an 8-bit CPU and the memories of a small handheld system. It turns each 16-bit CPU address into a memory target (I/O register file, RAM, flash or ROM), a physical byte address inside that target, and a write enable. The 64KB CPU space is split into eight 8KB windows selected by address bits 15:13, and bits 12:0 are the offset inside the page. Four control registers, written through the I/O area, choose the mapping. These are the bank index at I/O offset 0x00, the upper-window sub-page at 0x0A, the volume and alternate-RAM control at 0x0D, and the zero-page placement at 0x0F.

The mapping table is combinational in the register contents, so a control write that completes on one clock edge steers the very next access. The block also serves a wake-up key. While the wake-up flag is pending, a CPU read of RAM location 0x045F first writes the key byte into that location through the normal RAM write port, and the flag then clears.

Top module: `memwin_xlat`

## Requirements
- R1: Target codes are 0 none, 1 I/O, 2 RAM, 3 flash, 4 ROM. For every address at or above 0x80, the low 13 bits of the physical address equal the low 13 CPU address bits, and the window is picked by CPU address bits 15:13.
- R2: An address below 0x40 gives target I/O with the physical address equal to the CPU address, and it never raises the memory write enable.
- R3: Addresses 0x40 to 0x7F go to RAM, and their 6-bit offset is added to a base chosen by bits 2:0 of register 0x0F. Mode 0 uses base 0x40, modes 1 to 3 use base 0x00, and modes 4 to 7 use base 0x200 + 0x40*(mode-4).
- R4: Windows 2, 3, 4 and 5 take the parts of the 32KB bank at 0x4000, 0x6000, 0x0000 and 0x2000 respectively. A flash physical address is bank*0x8000 + part + offset.
- R5: A bank index below 16 (the flash page count) selects flash, and an index of 0x80 or above selects ROM. Any index between those gives target none.
- R6: A ROM physical address is volume*0x800000 + bank*0x8000 + part + offset. The volume is 1 when bit 0 of register 0x0D is set, 2 when only bit 1 is set, and 0 otherwise.
- R7: With bank index 0, windows 2 and 3 both map to RAM 0x4000 + offset, while windows 4 and 5 use flash bank 0.
- R8: Window 0 maps to RAM at the CPU address. Window 1 maps to RAM 0x6000 + offset when bit 2 of register 0x0D is set, and to RAM 0x2000 + offset otherwise.
- R9: The low nibble n of register 0x0A sets window 6 to ROM bank n/4. The part is taken in the order 0x4000, 0x6000, 0x0000, 0x2000 for n%4 = 0..3, from the selected volume. When n equals 1, window 6 maps to RAM 0x4000 + offset instead. Window 7 is always ROM bank 0 part 0x6000.
- R10: The write enable rises for a CPU write exactly when the target is RAM, so every write from 0x40 to 0x3FFF lands and writes to ROM, flash or unmapped targets are dropped.
- R11: A read of 0x045F while the wake-up flag is pending raises key_load and the write enable, with the write data equal to wake_key, and the flag clears afterwards. A wake_set pulse sets the flag, and it takes priority over a clear in the same cycle.
- R12: Reset clears all four control registers and the wake-up flag. A control register write affects the access in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| wake_set | input | 1 | Sets the wake-up pending flag |
| wake_key | input | 8 | Key byte loaded on the wake-up read |
| mem_tgt | output | 3 | Target code |
| mem_addr | output | 25 | Physical byte address inside the target |
| mem_we | output | 1 | Write enable toward memory |
| mem_wdata | output | 8 | Write data toward memory |
| key_load | output | 1 | This access loads the wake-up key |

## Verification
The assertions assume that cpu_rd and cpu_wr are never high together, and that every input is stable from the falling edge until the next rising edge. They also assume that wake_set is a single-cycle pulse driven independently of reads. The stimulus sets each input once per cycle right after the falling edge and drives at most one strobe. Most wake_set pulses fall on cycles that do not read the key address. One directed case makes the set and the clear coincide so that the priority rule is exercised.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
  localparam int OFF_W  = 13;
  localparam int PART_W = 2;
  localparam int BANK_W = 8;
  localparam int VOL_W  = 2;
  localparam int PA_W   = VOL_W + BANK_W + PART_W + OFF_W;
  localparam int RAM_W  = 16;

  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_IO    = 3'd1,
    TGT_RAM   = 3'd2,
    TGT_FLASH = 3'd3,
    TGT_ROM   = 3'd4
  } tgt_e;

  // zero-page placement: base chosen by the 3-bit mode plus a 6-bit offset
  function automatic logic [RAM_W-1:0] zp_ram_addr(logic [2:0] mode, logic [5:0] off);
    logic [RAM_W-1:0] base;
    if (mode == 3'd0)      base = 16'h0040;
    else if (!mode[2])     base = 16'h0000;
    else                   base = 16'h0200 | {8'd0, mode[1:0], 6'd0};
    return base | {10'd0, off};
  endfunction

  // windows 2..5 take bank parts 2,3,0,1 (0x4000,0x6000,0x0000,0x2000)
  function automatic logic [PART_W-1:0] bank_part(logic [2:0] win);
    return win[1:0];
  endfunction

  // sub-page order inside a bank: 0x4000, 0x6000, 0x0000, 0x2000
  function automatic logic [PART_W-1:0] sub_part(logic [1:0] k);
    return k ^ 2'b10;
  endfunction

  function automatic logic [VOL_W-1:0] vol_code(logic [1:0] ctl);
    if (ctl[0])      return 2'd1;
    else if (ctl[1]) return 2'd2;
    else             return 2'd0;
  endfunction

  function automatic logic [PA_W-1:0] paged_base(logic [VOL_W-1:0] vol,
                                                 logic [BANK_W-1:0] bank,
                                                 logic [PART_W-1:0] part);
    return {vol, bank, part, {OFF_W{1'b0}}};
  endfunction

  function automatic logic [PA_W-1:0] ram_base(logic [RAM_W-1:0] a);
    return {{(PA_W-RAM_W){1'b0}}, a};
  endfunction
endpackage

// File: rtl/memwin_regs.sv
module memwin_regs
  import memwin_pkg::*;
#(
  parameter logic [15:0] KEY_ADDR = 16'h045F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [7:0]  cpu_wdata,
  input  logic        wake_set,
  output logic [7:0]  bank_q,
  output logic [3:0]  sub_q,
  output logic [2:0]  volctl_q,
  output logic [2:0]  zp_q,
  output logic        key_take
);
  localparam logic [15:0] A_BANK = 16'h0000;
  localparam logic [15:0] A_SUB  = 16'h000A;
  localparam logic [15:0] A_VOL  = 16'h000D;
  localparam logic [15:0] A_ZP   = 16'h000F;

  logic wr_bank, wr_sub, wr_vol, wr_zp;
  logic pend_q;

  assign wr_bank  = cpu_wr && (cpu_addr == A_BANK);
  assign wr_sub   = cpu_wr && (cpu_addr == A_SUB);
  assign wr_vol   = cpu_wr && (cpu_addr == A_VOL);
  assign wr_zp    = cpu_wr && (cpu_addr == A_ZP);
  assign key_take = cpu_rd && (cpu_addr == KEY_ADDR) && pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q   <= '0;
      sub_q    <= '0;
      volctl_q <= '0;
      zp_q     <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (wr_bank) bank_q   <= cpu_wdata;
      if (wr_sub)  sub_q    <= cpu_wdata[3:0];
      if (wr_vol)  volctl_q <= cpu_wdata[2:0];
      if (wr_zp)   zp_q     <= cpu_wdata[2:0];
      if (wake_set)      pend_q <= 1'b1;
      else if (key_take) pend_q <= 1'b0;
    end
  end

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bank |=> bank_q == $past(cpu_wdata)); // R12
  AST_ZP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_zp |=> zp_q == $past(cpu_wdata[2:0])); // R12
  AST_WAKE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (key_take && !wake_set) |=> !pend_q); // R11
  AST_WAKE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wake_set |=> pend_q); // R11
endmodule

// File: rtl/memwin_winmap.sv
module memwin_winmap
  import memwin_pkg::*;
#(
  parameter int          FLASH_PAGES  = 16,
  parameter logic [15:0] ALT_RAM_BASE = 16'h6000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      bank_q,
  input  logic [3:0]      sub_q,
  input  logic [2:0]      volctl_q,
  output tgt_e            win_tgt  [8],
  output logic [PA_W-1:0] win_base [8]
);
  localparam logic [15:0] LOW_RAM_PAGE = 16'h4000;
  localparam int          NWIN         = 8;

  logic [VOL_W-1:0] vol;
  logic             bank_zero, bank_flash, bank_rom;

  assign vol        = vol_code(volctl_q[1:0]);
  assign bank_zero  = (bank_q == 8'd0);
  assign bank_flash = (int'(bank_q) < FLASH_PAGES);
  assign bank_rom   = bank_q[7];

  always_comb begin
    for (int w = 0; w < NWIN; w++) begin
      win_tgt[w]  = TGT_NONE;
      win_base[w] = '0;
      case (w)
        0: begin
          win_tgt[w]  = TGT_RAM;
          win_base[w] = ram_base(16'h0000);
        end
        1: begin
          win_tgt[w]  = TGT_RAM;
          win_base[w] = ram_base(volctl_q[2] ? ALT_RAM_BASE : 16'h2000);
        end
        2, 3, 4, 5: begin
          if (bank_zero && (w < 4)) begin
            win_tgt[w]  = TGT_RAM;
            win_base[w] = ram_base(LOW_RAM_PAGE);
          end else if (bank_flash) begin
            win_tgt[w]  = TGT_FLASH;
            win_base[w] = paged_base(2'd0, bank_q, bank_part(3'(w)));
          end else if (bank_rom) begin
            win_tgt[w]  = TGT_ROM;
            win_base[w] = paged_base(vol, bank_q, bank_part(3'(w)));
          end
        end
        6: begin
          if (sub_q == 4'd1) begin
            win_tgt[w]  = TGT_RAM;
            win_base[w] = ram_base(LOW_RAM_PAGE);
          end else begin
            win_tgt[w]  = TGT_ROM;
            win_base[w] = paged_base(vol, {6'd0, sub_q[3:2]}, sub_part(sub_q[1:0]));
          end
        end
        default: begin
          win_tgt[w]  = TGT_ROM;
          win_base[w] = paged_base(vol, 8'd0, sub_part(2'd1));
        end
      endcase
    end
  end

  AST_BANK0_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    bank_zero |-> (win_tgt[2] == TGT_RAM) && (win_tgt[3] == TGT_RAM)
                  && (win_base[2] == win_base[3])); // R7
  AST_TOP_WIN_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    win_tgt[7] == TGT_ROM); // R9
endmodule

// File: rtl/memwin_xlat.sv
module memwin_xlat
  import memwin_pkg::*;
#(
  parameter int          IO_LIMIT     = 64,
  parameter int          FLASH_PAGES  = 16,
  parameter logic [15:0] ALT_RAM_BASE = 16'h6000,
  parameter logic [15:0] KEY_ADDR     = 16'h045F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [7:0]  cpu_wdata,
  input  logic        wake_set,
  input  logic [7:0]  wake_key,
  output logic [2:0]  mem_tgt,
  output logic [24:0] mem_addr,
  output logic        mem_we,
  output logic [7:0]  mem_wdata,
  output logic        key_load
);
  localparam logic [15:0] IO_END  = 16'(IO_LIMIT);
  localparam logic [15:0] ZP_END  = 16'h0080;
  localparam logic [15:0] LOW_END = 16'h4000;

  logic [7:0]      bank_q;
  logic [3:0]      sub_q;
  logic [2:0]      volctl_q;
  logic [2:0]      zp_q;
  logic            key_take;
  tgt_e            win_tgt  [8];
  logic [PA_W-1:0] win_base [8];

  logic            io_hit, zp_hit;
  logic [2:0]      win_sel;
  tgt_e            tgt;
  logic [PA_W-1:0] phys;

  memwin_regs #(.KEY_ADDR(KEY_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .wake_set(wake_set),
    .bank_q(bank_q), .sub_q(sub_q), .volctl_q(volctl_q), .zp_q(zp_q),
    .key_take(key_take)
  );

  memwin_winmap #(.FLASH_PAGES(FLASH_PAGES), .ALT_RAM_BASE(ALT_RAM_BASE)) u_winmap (
    .clk(clk), .rst_n(rst_n), .bank_q(bank_q), .sub_q(sub_q),
    .volctl_q(volctl_q), .win_tgt(win_tgt), .win_base(win_base)
  );

  assign io_hit  = (cpu_addr < IO_END);
  assign zp_hit  = !io_hit && (cpu_addr < ZP_END);
  assign win_sel = cpu_addr[15:13];

  always_comb begin
    if (io_hit) begin
      tgt  = TGT_IO;
      phys = ram_base(cpu_addr);
    end else if (zp_hit) begin
      tgt  = TGT_RAM;
      phys = ram_base(zp_ram_addr(zp_q, cpu_addr[5:0]));
    end else begin
      tgt  = win_tgt[win_sel];
      phys = win_base[win_sel] | {{(PA_W-OFF_W){1'b0}}, cpu_addr[OFF_W-1:0]};
    end
  end

  assign mem_tgt   = tgt;
  assign mem_addr  = phys;
  assign key_load  = key_take;
  assign mem_we    = key_take || (cpu_wr && (tgt == TGT_RAM));
  assign mem_wdata = key_take ? wake_key : cpu_wdata;

  AST_WE_RAM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_tgt == TGT_RAM); // R10
  AST_LOW_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !io_hit && (cpu_addr < LOW_END)) |-> mem_we); // R10
  AST_IO_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> (mem_tgt == TGT_IO) && !mem_we); // R2
  AST_ZP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    zp_hit |-> (mem_addr < 25'h0000400) && (mem_tgt == TGT_RAM)); // R3
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr >= ZP_END) |-> mem_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]); // R1
endmodule

// File: tb/memwin_xlat_bench.sv
module memwin_xlat_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0, wake_set = 1'b0;
  logic [7:0]  cpu_wdata = '0, wake_key = 8'h5A;
  logic [2:0]  mem_tgt;
  logic [24:0] mem_addr;
  logic        mem_we, key_load;
  logic [7:0]  mem_wdata;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  // reference state
  int m_bank = 0, m_sub = 0, m_vol = 0, m_zp = 0;
  bit m_pend = 0;

  memwin_xlat u_memwin_xlat (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .wake_set(wake_set),
    .wake_key(wake_key), .mem_tgt(mem_tgt), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .key_load(key_load)
  );

  always #10 clk = ~clk;

  task automatic check(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int part_of(int k); // k: 0..3 -> part in order 4000,6000,0000,2000
    case (k)
      0: return 'h4000;
      1: return 'h6000;
      2: return 'h0000;
      default: return 'h2000;
    endcase
  endfunction

  function automatic void model(int a, output int t, output int p);
    int w, off, vol, nib;
    w = a / 8192; off = a % 8192;
    vol = (m_vol % 2 == 1) ? 1 : (((m_vol / 2) % 2 == 1) ? 2 : 0);
    nib = m_sub;
    if (a < 64) begin t = 1; p = a; end
    else if (a < 128) begin
      t = 2;
      if (m_zp == 0) p = 64 + (a - 64);
      else if (m_zp <= 3) p = a - 64;
      else p = 512 + 64 * (m_zp - 4) + (a - 64);
    end else if (w == 0) begin t = 2; p = a; end
    else if (w == 1) begin t = 2; p = (((m_vol / 4) % 2 == 1) ? 'h6000 : 'h2000) + off; end
    else if (w <= 5) begin
      int h;
      h = (w == 2) ? 'h4000 : (w == 3) ? 'h6000 : (w == 4) ? 0 : 'h2000;
      if (m_bank == 0 && w < 4) begin t = 2; p = 'h4000 + off; end
      else if (m_bank < 16) begin t = 3; p = m_bank * 32768 + h + off; end
      else if (m_bank >= 128) begin t = 4; p = vol * 8388608 + m_bank * 32768 + h + off; end
      else begin t = 0; p = off; end
    end else if (w == 6) begin
      if (nib == 1) begin t = 2; p = 'h4000 + off; end
      else begin t = 4; p = vol * 8388608 + (nib / 4) * 32768 + part_of(nib % 4) + off; end
    end else begin
      t = 4; p = vol * 8388608 + part_of(1) + off;
    end
  endfunction

  function automatic string classify(int a);
    int w;
    w = a / 8192;
    if (a < 64) return "R2";
    if (a < 128) return "R3";
    if (w <= 1) return "R8";
    if (w <= 5) return (m_bank == 0 && w < 4) ? "R7" : (m_bank >= 128 ? "R6" : "R5");
    return "R9";
  endfunction

  task automatic step(int a, bit rd, bit wr, int d, bit ws, string tag);
    int t, p, ew;
    bit ek;
    cpu_addr = 16'(a); cpu_rd = rd; cpu_wr = wr; cpu_wdata = 8'(d); wake_set = ws;
    #2;
    model(a, t, p);
    ek = rd && (a == 'h045F) && m_pend;
    ew = (ek || (wr && t == 2)) ? 1 : 0;
    check(tag, "target", int'(mem_tgt), t);
    check(tag, "address", int'(mem_addr), p);
    check("R10", "write enable", int'(mem_we), ew);
    check("R11", "key load", int'(key_load), int'(ek));
    if (ew == 1) check(ek ? "R11" : "R10", "write data", int'(mem_wdata), ek ? int'(wake_key) : (d % 256));
    @(posedge clk);
    if (wr) begin
      if (a == 'h00) m_bank = d % 256;
      if (a == 'h0A) m_sub = d % 16;
      if (a == 'h0D) m_vol = d % 8;
      if (a == 'h0F) m_zp = d % 8;
    end
    if (ws) m_pend = 1;
    else if (ek) m_pend = 0;
    @(negedge clk);
    cpu_rd = 0; cpu_wr = 0; wake_set = 0;
  endtask

  task automatic rd(int a, string tag);  step(a, 1, 0, 0, 0, tag); endtask
  task automatic wr(int a, int d, string tag); step(a, 0, 1, d, 0, tag); endtask

  function automatic int rand_reg_val(int a);
    int s;
    s = int'($urandom % 4);
    if (a == 'h00) begin
      case (s)
        0: return 0;
        1: return int'($urandom % 16);
        2: return 16 + int'($urandom % 112);
        default: return 128 + int'($urandom % 128);
      endcase
    end
    return int'($urandom % 256);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state, bank 0 / volume 0 / sub-page 0
    rd('h4000, "R12");
    rd('hC000, "R12");
    rd('h0050, "R12");
    rd('h045F, "R12");
    // R2: I/O area
    rd('h0010, "R2");
    wr('h0005, 'h33, "R2");
    // R3: zero-page modes
    for (int m = 0; m < 8; m++) begin
      wr('h000F, m + 8 * m, "R2");
      rd('h0045, "R3");
      wr('h007F, m, "R3");
    end
    // R8: windows 0 and 1
    rd('h1234, "R8");
    rd('h2345, "R8");
    wr('h000D, 'h04, "R2");
    rd('h2345, "R8");
    wr('h3FFF, 'h77, "R10");
    wr('h000D, 'h00, "R2");
    rd('h2345, "R8");
    // R7: bank 0
    rd('h4001, "R7"); rd('h6002, "R7"); rd('h8003, "R7"); rd('hA004, "R7");
    wr('h5000, 'h11, "R7");
    // R4 / R5: flash banks and gap
    wr('h0000, 5, "R2");
    rd('h4010, "R4"); rd('h6010, "R4"); rd('h8010, "R4"); rd('hA010, "R4");
    wr('h8010, 'h22, "R10");
    wr('h0000, 15, "R2"); rd('h9ABC, "R5");
    wr('h0000, 16, "R2"); rd('h9ABC, "R5");
    wr('h9000, 'h44, "R10");
    wr('h0000, 'h7F, "R2"); rd('h4321, "R5");
    // R6: ROM volumes
    wr('h0000, 'h80, "R12");
    rd('h8000, "R12");
    for (int v = 0; v < 4; v++) begin
      wr('h000D, v, "R2");
      rd('h8000, "R6");
      rd('h5FFF, "R6");
    end
    wr('h8000, 'h55, "R10");
    wr('h0000, 'hFF, "R2"); rd('hBFFF, "R6");
    // R9: upper windows
    for (int n = 0; n < 16; n++) begin
      wr('h000A, n + 16 * (n % 3), "R2");
      rd('hC000 + n, "R9");
      rd('hE123, "R9");
    end
    wr('h000A, 1, "R2");
    wr('hC010, 'h66, "R10");
    wr('hE010, 'h66, "R10");
    // R11: wake-up key
    rd('h045F, "R11");
    wake_key = 8'hA7;
    step('h0100, 1, 0, 0, 1, "R8");
    rd('h045F, "R11");
    rd('h045F, "R11");
    step('h0100, 1, 0, 0, 1, "R8");
    step('h045F, 1, 0, 0, 1, "R11");
    rd('h045F, "R11");
    rd('h045F, "R11");
    // R1: offsets across windows
    for (int i = 0; i < 300; i++) begin
      int a;
      a = 128 + int'($urandom % 65408);
      if (i % 50 == 0) wr('h0000, rand_reg_val(0), "R2");
      rd(a, "R1");
    end
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      int op, a;
      op = int'($urandom % 10);
      if (op < 2) begin
        case ($urandom % 4)
          0: a = 'h00;
          1: a = 'h0A;
          2: a = 'h0D;
          default: a = 'h0F;
        endcase
        wr(a, rand_reg_val(a), "R2");
      end else if (op == 2) begin
        wake_key = 8'($urandom);
        step(128 + int'($urandom % 1000), 1, 0, 0, 1, "R1");
      end else if (op == 3) begin
        a = int'($urandom % 65536);
        if (a < 64) a = a + 64;
        wr(a, int'($urandom % 256), classify(a));
      end else begin
        a = (op == 4) ? 'h045F : int'($urandom % 65536);
        rd(a, classify(a));
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule